// File: doc/BRIEF.md
# Debug Halt and Register-Transfer Unit

This block sits on the target side of a debug link. It gives an external debugger, reaching it over a small 32-bit register bus, control over whether a core runs, halts or executes a single instruction. It also gives indirect access to the core's seventeen architectural registers: r0 to r12, then sp, lr, pc and xpsr. The core itself lies outside the block. The block drives a halt level and a step pulse toward it, receives a step-completion pulse and a reset-exit pulse, and reaches the core's register file through a select/read/write port.

The debugger uses four word registers, at byte offsets 0x0, 0x4, 0x8 and 0xC. These are the run control and status register, the transfer selector, the transfer data register and the monitor register. A run control write changes anything only when its upper half holds the key value 0xA05F. A register transfer starts with a write to the selector. The selector holds a register number and a direction. The transfer completes after a fixed two cycles, and a ready flag in the status word shows when it is done. When the monitor register arms catch-on-reset, the core is stopped as soon as it comes out of reset.

The bus request channel is valid/ready. A request moves when `bus_valid` and `bus_ready` are both high. Writes produce no response. A read produces exactly one response beat on `rsp_valid`/`rsp_data`. That beat stays valid and unchanged until `rsp_ready` is high. While a beat is stalled, `bus_ready` is low, so no request can be lost.

Top module: `dbg_halt_unit`

## Requirements
- R1: After reset, the enable, halt and step control bits are 0, `core_halt` is low, the ready flag reads 1, the monitor register reads 0, and the data register reads 0.
- R2: A run control write whose bits 31:16 differ from 0xA05F leaves the enable, halt and step bits unchanged.
- R3: A keyed run control write loads enable from bit 0, halt from bit 1 and step from bit 2. Low bits 3'b011 halt the core (`core_halt` high), and 3'b001 resumes it (`core_halt` low).
- R4: A keyed write with low bits 3'b101 emits one `core_step` pulse on the next cycle. It keeps `core_halt` low until `core_step_done` is seen, and `core_halt` is high on the cycle after that pulse.
- R5: A run control/status read returns enable in bit 0, halt in bit 1, step in bit 2, the ready flag in bit 16 and the core-halted state in bit 17. All other bits read 0.
- R6: A selector write with bit 16 clear copies core register N into the data register, where N is bits 4:0 of the selector. Numbers 0 to 12 are r0 to r12, 13 is sp, 14 is lr, 15 is pc and 16 is xpsr, and N appears on `rf_sel`.
- R7: A selector write with bit 16 set writes the data register into core register N through one `rf_we` cycle. The selector reads back with N in bits 4:0 and the direction in bit 16.
- R8: An accepted selector write clears the ready flag. The flag reads 0 for the two cycles that follow and 1 from the third cycle onward.
- R9: A selector write while the core is not halted is ignored: the ready flag stays 1, the data register and the core registers are unchanged.
- R10: Selector numbers 17 to 31 transfer a value of zero into the data register on a read and never assert `rf_we`.
- R11: When monitor bit 0 is set, a `core_rst_exit` pulse sets enable and halt and clears step, so `core_halt` is high on the next cycle. This also holds when a keyed resume write arrives in the same cycle. With monitor bit 0 clear, the pulse has no effect.
- R12: A read response stays valid with unchanged data while `rsp_ready` is low, and `bus_ready` is low for the whole stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request can be accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Debugger takes the response |
| rsp_data | output | 32 | Read response data |
| core_halt | output | 1 | Level: core must stay halted |
| core_step | output | 1 | One-cycle pulse: execute one instruction |
| core_step_done | input | 1 | Pulse: stepped instruction retired |
| core_rst_exit | input | 1 | Pulse: core is leaving reset |
| rf_sel | output | 5 | Core register number |
| rf_we | output | 1 | Core register write strobe |
| rf_wdata | output | 32 | Core register write value |
| rf_rdata | input | 32 | Core register read value for `rf_sel` |

## Verification
Two functions can land on the same edge: the catch-on-reset event and a keyed resume write from the debugger. Both update the same enable and halt bits. The bench drives `core_rst_exit` and the keyed resume request at the same negative edge, so that both are sampled by one rising edge. It then reads the status word and expects the core still halted, since the catch event takes priority. The bench also repeats the reset-exit pulse with the monitor bit cleared, which confirms that the priority comes from the arming bit and not from the pulse alone.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned KEY_W    = 16;
  localparam logic [15:0] RUN_KEY  = 16'hA05F;
  localparam int unsigned DIR_BIT  = 16;
  localparam int unsigned RDY_BIT  = 16;
  localparam int unsigned HLT_BIT  = 17;

  // register index taken from byte offset bits 3:2
  typedef enum logic [1:0] {
    RG_RUN  = 2'd0,
    RG_SEL  = 2'd1,
    RG_DATA = 2'd2,
    RG_MON  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
  import dbg_pkg::*;
#(
  parameter logic [15:0] KEY = RUN_KEY
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_we,
  input  logic [15:0] run_key,
  input  logic [2:0]  run_bits,
  input  logic        mon_we,
  input  logic        mon_bit,
  input  logic        rst_exit,
  input  logic        step_done,
  output logic        en_q,
  output logic        halt_q,
  output logic        step_q,
  output logic        catch_q,
  output logic        core_halt,
  output logic        core_step
);
  logic stepping_q;
  logic catch_fire;
  logic key_ok;

  assign catch_fire = catch_q & rst_exit;
  assign key_ok     = (run_key == KEY);
  assign core_halt  = en_q & (halt_q | step_q) & ~stepping_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      halt_q     <= 1'b0;
      step_q     <= 1'b0;
      catch_q    <= 1'b0;
      stepping_q <= 1'b0;
      core_step  <= 1'b0;
    end else begin
      core_step <= 1'b0;
      if (mon_we) catch_q <= mon_bit;
      if (catch_fire) begin
        en_q       <= 1'b1;
        halt_q     <= 1'b1;
        step_q     <= 1'b0;
        stepping_q <= 1'b0;
      end else if (run_we && key_ok) begin
        en_q   <= run_bits[0];
        halt_q <= run_bits[1];
        step_q <= run_bits[2];
        if (run_bits[0] && run_bits[2]) begin
          stepping_q <= 1'b1;
          core_step  <= 1'b1;
        end else begin
          stepping_q <= 1'b0;
        end
      end else if (stepping_q && step_done) begin
        stepping_q <= 1'b0;
      end
    end
  end

  // R2: an unkeyed write leaves the run bits alone
  p_key_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_we && !key_ok && !catch_fire) |=> $stable({en_q, halt_q, step_q}));

  // R4: the step pulse is only issued while the core is released
  p_step_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_step |-> !core_halt);

  // R4: step completion returns the core to halt
  p_step_rehalt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping_q && step_done && !run_we && !catch_fire && en_q && step_q) |=> core_halt);

  // R11: armed reset exit stops the core, whatever the bus does
  p_catch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_exit && catch_q) |=> core_halt);
endmodule

// File: rtl/dbg_reg_xfer.sv
module dbg_reg_xfer
  import dbg_pkg::*;
#(
  parameter int unsigned NREG     = 17,
  parameter int unsigned XFER_CYC = 2,
  localparam int unsigned SELW    = $clog2(NREG),
  localparam int unsigned CW      = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_we,
  input  logic            data_we,
  input  logic [DW-1:0]   wdata,
  input  logic            halted,
  input  logic [DW-1:0]   rf_rdata,
  output logic [DW-1:0]   sel_rb,
  output logic [DW-1:0]   data_q,
  output logic            ready_q,
  output logic [SELW-1:0] rf_sel,
  output logic            rf_we,
  output logic [DW-1:0]   rf_wdata
);
  localparam logic [SELW-1:0] LAST = SELW'(NREG - 1);
  localparam logic [CW-1:0]   CEND = CW'(XFER_CYC - 1);

  logic [SELW-1:0] sel_q;
  logic            dir_q;
  logic [CW-1:0]   cnt_q;
  logic            code_ok;
  logic            start;
  logic            unused_bits;

  assign unused_bits = &{1'b0, wdata[DW-1:DIR_BIT+1], wdata[DIR_BIT-1:SELW]};
  assign code_ok  = (sel_q <= LAST);
  assign start    = sel_we & halted & ready_q;
  assign rf_sel   = sel_q;
  assign rf_wdata = data_q;
  assign rf_we    = ~ready_q & dir_q & (cnt_q == '0) & code_ok;

  always_comb begin
    sel_rb            = '0;
    sel_rb[SELW-1:0]  = sel_q;
    sel_rb[DIR_BIT]   = dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      dir_q   <= 1'b0;
      cnt_q   <= '0;
      data_q  <= '0;
      ready_q <= 1'b1;
    end else if (start) begin
      sel_q   <= wdata[SELW-1:0];
      dir_q   <= wdata[DIR_BIT];
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0 && !dir_q) data_q <= code_ok ? rf_rdata : '0;
      if (cnt_q == CEND) ready_q <= 1'b1;
    end else if (data_we) begin
      data_q <= wdata;
    end
  end

  // R8: accepted selector write drops ready on the next cycle
  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready_q);

  // R9: a selector write with the core running changes nothing
  p_run_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && !halted && ready_q) |=> (ready_q && $stable(data_q)));

  // R10: out-of-range numbers never reach the register file
  p_no_bad_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_sel <= LAST));
endmodule

// File: rtl/dbg_halt_unit.sv
module dbg_halt_unit
  import dbg_pkg::*;
#(
  parameter int unsigned NREG     = 17,
  parameter int unsigned XFER_CYC = 2,
  localparam int unsigned SELW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  output logic            bus_ready,
  input  logic            bus_write,
  input  logic [3:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  output logic            core_halt,
  output logic            core_step,
  input  logic            core_step_done,
  input  logic            core_rst_exit,
  output logic [SELW-1:0] rf_sel,
  output logic            rf_we,
  output logic [DW-1:0]   rf_wdata,
  input  logic [DW-1:0]   rf_rdata
);
  reg_idx_e      idx;
  logic          acc, wr, rd;
  logic          en_q, halt_q, step_q, catch_q, ready_q;
  logic [DW-1:0] sel_rb, data_q, rd_mux, run_rb;
  logic          unused_addr;

  assign unused_addr = &{1'b0, bus_addr[1:0]};
  assign idx       = reg_idx_e'(bus_addr[3:2]);
  assign bus_ready = ~rsp_valid | rsp_ready;
  assign acc       = bus_valid & bus_ready;
  assign wr        = acc & bus_write;
  assign rd        = acc & ~bus_write;

  dbg_run_ctrl u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_we    (wr && idx == RG_RUN),
    .run_key   (bus_wdata[DW-1:DW-KEY_W]),
    .run_bits  (bus_wdata[2:0]),
    .mon_we    (wr && idx == RG_MON),
    .mon_bit   (bus_wdata[0]),
    .rst_exit  (core_rst_exit),
    .step_done (core_step_done),
    .en_q      (en_q),
    .halt_q    (halt_q),
    .step_q    (step_q),
    .catch_q   (catch_q),
    .core_halt (core_halt),
    .core_step (core_step)
  );

  dbg_reg_xfer #(.NREG(NREG), .XFER_CYC(XFER_CYC)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (wr && idx == RG_SEL),
    .data_we  (wr && idx == RG_DATA),
    .wdata    (bus_wdata),
    .halted   (core_halt),
    .rf_rdata (rf_rdata),
    .sel_rb   (sel_rb),
    .data_q   (data_q),
    .ready_q  (ready_q),
    .rf_sel   (rf_sel),
    .rf_we    (rf_we),
    .rf_wdata (rf_wdata)
  );

  always_comb begin
    run_rb          = '0;
    run_rb[0]       = en_q;
    run_rb[1]       = halt_q;
    run_rb[2]       = step_q;
    run_rb[RDY_BIT] = ready_q;
    run_rb[HLT_BIT] = core_halt;
    unique case (idx)
      RG_RUN:  rd_mux = run_rb;
      RG_SEL:  rd_mux = sel_rb;
      RG_DATA: rd_mux = data_q;
      default: rd_mux = {{(DW-1){1'b0}}, catch_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R12: a stalled response holds its data and blocks new requests
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_stall_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !bus_ready);
endmodule

// File: tb/tb_dbg_halt_unit.sv
module tb_dbg_halt_unit;
  localparam int CLK_P = 10;
  localparam int NV    = 6;
  // {write value, expected {halted, step, halt, enable}} applied in order
  localparam logic [35:0] VEC [NV] = '{
    {32'h1234_0003, 4'b0000},
    {32'hA05F_0003, 4'b1011},
    {32'hA05E_0001, 4'b1011},
    {32'hA05F_0001, 4'b0001},
    {32'hA05F_0003, 4'b1011},
    {32'h005F_0001, 4'b1011}
  };

  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_write = 0, rsp_ready = 1;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic        bus_ready, rsp_valid, core_halt, core_step, rf_we;
  logic [31:0] rsp_data, rf_wdata, rf_rdata;
  logic        core_step_done = 0, core_rst_exit = 0;
  logic [4:0]  rf_sel;
  logic [31:0] stub [17];
  int          n_run = 0, n_fail = 0;
  logic [31:0] d;

  always #(CLK_P/2) clk = ~clk;

  dbg_halt_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .core_halt(core_halt), .core_step(core_step), .core_step_done(core_step_done),
    .core_rst_exit(core_rst_exit), .rf_sel(rf_sel), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // core register file stub; out-of-range numbers return a marker
  assign rf_rdata = (rf_sel < 5'd17) ? stub[rf_sel] : 32'hDEAD_BEEF;
  always @(posedge clk) if (rf_we && rf_sel < 5'd17) stub[rf_sel] <= rf_wdata;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = v;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 0;
    v = rsp_data;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 17; i++) stub[i] = 32'h1000_0000 + i;
    idle(2);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rd(4'h0, d); check("R1 status", d, 32'h0001_0000);
    rd(4'hC, d); check("R1 monitor", d, 32'h0);
    rd(4'h8, d); check("R1 data", d, 32'h0);
    check("R1 core_halt", {31'b0, core_halt}, 32'h0);

    // R2 R3 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      wr(4'h0, VEC[i][35:4]);
      rd(4'h0, d);
      check("R2/R3 R5 status bits", {28'b0, d[17], d[2:0]}, {28'b0, VEC[i][3:0]});
    end
    check("R3 core_halt level", {31'b0, core_halt}, 32'h1);

    // R6 read pc (15) with R8 ready timing
    wr(4'h4, 32'h0000_000F);
    rd(4'h0, d); check("R8 ready cycle1", {31'b0, d[16]}, 32'h0);
    rd(4'h0, d); check("R8 ready cycle2", {31'b0, d[16]}, 32'h0);
    rd(4'h0, d); check("R8 ready cycle3", {31'b0, d[16]}, 32'h1);
    rd(4'h8, d); check("R6 pc read", d, 32'h1000_000F);
    wr(4'h4, 32'h0000_000D); idle(2);
    rd(4'h8, d); check("R6 sp read", d, 32'h1000_000D);

    // R7 write r3
    wr(4'h8, 32'hCAFE_0003);
    wr(4'h4, 32'h0001_0003); idle(2);
    check("R7 r3 written", stub[3], 32'hCAFE_0003);
    rd(4'h4, d); check("R7 selector readback", d, 32'h0001_0003);

    // R10 unused code
    wr(4'h4, 32'h0000_0014); idle(2);
    rd(4'h8, d); check("R10 unused reads zero", d, 32'h0);
    wr(4'h8, 32'h5555_AAAA);
    wr(4'h4, 32'h0001_0014); idle(2);
    check("R10 no stub change", stub[16], 32'h1000_0010);
    rd(4'h8, d); check("R10 data kept", d, 32'h5555_AAAA);

    // R9 transfer while running
    wr(4'h0, 32'hA05F_0001);
    wr(4'h8, 32'h7777_0000);
    wr(4'h4, 32'h0001_0002);
    rd(4'h0, d); check("R9 ready stays", {31'b0, d[16]}, 32'h1);
    idle(2);
    check("R9 r2 untouched", stub[2], 32'h1000_0002);
    rd(4'h8, d); check("R9 data untouched", d, 32'h7777_0000);

    // R4 single step
    wr(4'h0, 32'hA05F_0003);
    bus_valid = 1; bus_write = 1; bus_addr = 4'h0; bus_wdata = 32'hA05F_0005;
    @(posedge clk); @(negedge clk);
    bus_valid = 0; bus_write = 0;
    check("R4 step pulse", {31'b0, core_step}, 32'h1);
    check("R4 released", {31'b0, core_halt}, 32'h0);
    idle(1);
    check("R4 single pulse", {31'b0, core_step}, 32'h0);
    check("R4 still released", {31'b0, core_halt}, 32'h0);
    core_step_done = 1; @(posedge clk); @(negedge clk); core_step_done = 0;
    check("R4 halted after step", {31'b0, core_halt}, 32'h1);

    // R12 stalled response
    rsp_ready = 0;
    rd(4'h0, d);
    idle(2);
    check("R12 valid held", {31'b0, rsp_valid}, 32'h1);
    check("R12 data held", rsp_data, d);
    check("R12 request blocked", {31'b0, bus_ready}, 32'h0);
    rsp_ready = 1; idle(1);

    // R11 catch on reset
    wr(4'hC, 32'h1);
    wr(4'h0, 32'hA05F_0001);
    core_rst_exit = 1; @(posedge clk); @(negedge clk); core_rst_exit = 0;
    rd(4'h0, d); check("R11 catch halts", {28'b0, d[17], d[2:0]}, 32'hB);
    wr(4'h0, 32'hA05F_0001);
    core_rst_exit = 1; bus_valid = 1; bus_write = 1; bus_addr = 4'h0;
    bus_wdata = 32'hA05F_0001;
    @(posedge clk); @(negedge clk);
    core_rst_exit = 0; bus_valid = 0; bus_write = 0;
    rd(4'h0, d); check("R11 catch beats resume", {31'b0, d[17]}, 32'h1);
    wr(4'hC, 32'h0);
    wr(4'h0, 32'hA05F_0001);
    core_rst_exit = 1; @(posedge clk); @(negedge clk); core_rst_exit = 0;
    rd(4'h0, d); check("R11 disarmed no halt", {31'b0, d[17]}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule